// File: doc/BRIEF.md
# Sampled Quadrature Encoder Interface

This block turns the two phase outputs of one incremental shaft encoder into a signed position count. Both phase lines first pass through a two-flop synchroniser. They are then examined together, only on a slow periodic sample strobe, which is nominally 153.257 kHz (one sample every 6.525 us). Decoding resolution is selectable. The choices are a plain single-input counter, a one-count-per-cycle mode, a two-count-per-cycle mode and a full four-count-per-cycle mode. If both phases change within one sample, the order of the two changes is lost. Such a step is rejected and counted as an error.

The block also measures the number of sample strobes between successive counted edges, so software can derive speed. This interval saturates at all ones when the shaft has stopped. The host pulses a latch input to take a coherent snapshot of position, interval, direction and error count. All four outputs come from that snapshot, so the host reads them without any interrupt.

Top module: `quad_sample_decoder`

## Requirements
- R1: Phase changes reach the count only through strobe-gated samples of the synchronised inputs. The live state never changes in a cycle without a strobe, and a change cannot show in a snapshot taken before it has crossed the synchroniser.
- R2: With mode_i = 3 (4x), every single-phase change counts. With the sample state written as {A,B}, the step 00→01→11→10→00 adds 1 and sets dir_o = 1, and the reverse order subtracts 1 and sets dir_o = 0.
- R3: With mode_i = 1 (1x), only rising A counts. It adds 1 when B is 1 and subtracts 1 when B is 0. Falling A and B changes leave the count unchanged.
- R4: With mode_i = 2 (2x), both edges of A count. The step adds 1 when the new A equals B and subtracts 1 otherwise. B changes alone leave the count unchanged.
- R5: With mode_i = 0 (counter), each rising A adds 1 and sets dir_o = 1. B is ignored, and no step is ever flagged as an error.
- R6: In modes 1, 2 and 3, a sample where A and B both changed leaves position and direction unchanged and increments the error count. The error count saturates at all ones.
- R7: On each counted edge, the interval value becomes the number of strobes since the previous counted edge.
- R8: When 2^PER_W-1 strobes pass without a counted edge, the interval reads all ones (stopped).
- R9: A pulse on latch_i copies position, interval, direction and error count in the same cycle. Without a latch, the outputs hold.
- R10: Reset (rst_ni low) clears position, direction and error count to 0 and sets the interval to all ones, both live and on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | 1 | Phase A, asynchronous |
| b_i | input | 1 | Phase B, asynchronous |
| mode_i | input | 2 | 0 counter, 1 1x, 2 2x, 3 4x |
| latch_i | input | 1 | Snapshot request, one cycle |
| pos_o | output | CNT_W | Snapshot signed position |
| period_o | output | PER_W | Snapshot strobes between counted edges |
| dir_o | output | 1 | Snapshot direction, 1 = up |
| err_cnt_o | output | ERR_W | Snapshot unresolvable-step count |

## Verification
The assertions assume that mode_i changes only together with, or between, phase steps. They also assume that latch_i is a single-cycle pulse, and that the strobe divider is at least two, so strobes never fall on adjacent cycles. The stimulus holds every phase state for at least two full strobe periods, which is enough for each intended step to be sampled exactly once. It forces simultaneous A/B changes deliberately, within a single clock, so that the rejected step is certain. Interval checks space counted edges by whole multiples of the strobe period, so the measured strobe count is exact whatever the strobe phase.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  typedef enum logic [1:0] {
    MODE_CNT = 2'd0,
    MODE_X1  = 2'd1,
    MODE_X2  = 2'd2,
    MODE_X4  = 2'd3
  } mode_e;

  // forward Gray order on {a,b}: 00 -> 01 -> 11 -> 10 -> 00
  function automatic logic [1:0] gray_fwd(input logic [1:0] s);
    case (s)
      2'b00:   return 2'b01;
      2'b01:   return 2'b11;
      2'b11:   return 2'b10;
      default: return 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int N_CH   = 2,
  parameter int STAGES = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] d_i,
  output logic [N_CH-1:0] q_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [STAGES-1:0] sr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sr_q <= '0;
      else         sr_q <= {sr_q[STAGES-2:0], d_i[c]};
    end
    assign q_o[c] = sr_q[STAGES-1];
  end
endmodule

// File: rtl/qdec_strobe.sv
module qdec_strobe #(
  parameter int DIV = 653
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic stb_o
);
  if (DIV < 2) begin : g_every
    assign stb_o = 1'b1;
  end else begin : g_div
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    logic [CW-1:0] cnt_q;
    logic          stb_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q <= '0;
        stb_q <= 1'b0;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
        stb_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        stb_q <= 1'b0;
      end
    end
    assign stb_o = stb_q;

    p_stb_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_q |=> !stb_q);
  end
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int ERR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  mode_e            mode_i,
  input  logic [1:0]       ab_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] pos_o,
  output logic             dir_o,
  output logic [ERR_W-1:0] err_o
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [1:0]       prev_q;
  logic [CNT_W-1:0] pos_q;
  logic             dir_q;
  logic [ERR_W-1:0] err_q;
  logic             a_chg, b_chg, up, dn, bad;

  assign a_chg = ab_i[1] ^ prev_q[1];
  assign b_chg = ab_i[0] ^ prev_q[0];

  always_comb begin
    up  = 1'b0;
    dn  = 1'b0;
    bad = 1'b0;
    if (stb_i) begin
      if (mode_i == MODE_CNT) begin
        up = a_chg & ab_i[1];
      end else if (a_chg && b_chg) begin
        bad = 1'b1;
      end else begin
        unique case (mode_i)
          MODE_X1: if (a_chg && ab_i[1]) begin
            up = ab_i[0];
            dn = !ab_i[0];
          end
          MODE_X2: if (a_chg) begin
            up = (ab_i[1] == ab_i[0]);
            dn = (ab_i[1] != ab_i[0]);
          end
          default: if (a_chg || b_chg) begin
            up = (ab_i == gray_fwd(prev_q));
            dn = (ab_i != gray_fwd(prev_q));
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pos_q  <= '0;
      dir_q  <= 1'b0;
      err_q  <= '0;
    end else if (stb_i) begin
      prev_q <= ab_i;
      if (up) begin
        pos_q <= pos_q + ONE;
        dir_q <= 1'b1;
      end else if (dn) begin
        pos_q <= pos_q - ONE;
        dir_q <= 1'b0;
      end
      if (bad && err_q != ERR_MAX) err_q <= err_q + 1'b1;
    end
  end

  assign edge_o = up | dn;
  assign pos_o  = pos_q;
  assign dir_o  = dir_q;
  assign err_o  = err_q;

  p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> $stable(pos_q) && $stable(err_q) && $stable(dir_q));
  p_unit_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == $past(pos_q)) || (pos_q == $past(pos_q) + ONE) || (pos_q == $past(pos_q) - ONE));
  p_cnt_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && mode_i == MODE_CNT && a_chg && ab_i[1]) |=> dir_q);
  p_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && mode_i != MODE_CNT && a_chg && b_chg) |=> $stable(pos_q) && $stable(dir_q));
  p_err_mono_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q >= $past(err_q));
endmodule

// File: rtl/qdec_period.sv
module qdec_period #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stb_i,
  input  logic             edge_i,
  output logic [PER_W-1:0] per_o
);
  localparam logic [PER_W-1:0] PER_MAX = '1;

  logic [PER_W-1:0] run_q, per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= PER_MAX;
      per_q <= PER_MAX;
    end else if (stb_i) begin
      if (edge_i) begin
        per_q <= (run_q == PER_MAX) ? PER_MAX : run_q + 1'b1;
        run_q <= '0;
      end else if (run_q != PER_MAX) begin
        run_q <= run_q + 1'b1;
        if (run_q == PER_MAX - 1'b1) per_q <= PER_MAX;
      end
    end
  end

  assign per_o = per_q;

  p_per_nonzero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q != '0);
  p_run_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && edge_i) |=> run_q == '0);
  p_stopped_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == PER_MAX) |-> (per_q == PER_MAX));
endmodule

// File: rtl/quad_sample_decoder.sv
module quad_sample_decoder
  import qdec_pkg::*;
#(
  parameter int CLK_DIV = 653,
  parameter int CNT_W   = 32,
  parameter int PER_W   = 16,
  parameter int ERR_W   = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             a_i,
  input  logic             b_i,
  input  logic [1:0]       mode_i,
  input  logic             latch_i,
  output logic [CNT_W-1:0] pos_o,
  output logic [PER_W-1:0] period_o,
  output logic             dir_o,
  output logic [ERR_W-1:0] err_cnt_o
);
  logic [1:0]       ab_s;
  logic             stb, cnt_edge, dir_l;
  logic [CNT_W-1:0] pos_l;
  logic [PER_W-1:0] per_l;
  logic [ERR_W-1:0] err_l;

  qdec_sync #(.N_CH(2), .STAGES(2)) u_sync (
    .clk_i, .rst_ni, .d_i({a_i, b_i}), .q_o(ab_s)
  );

  qdec_strobe #(.DIV(CLK_DIV)) u_stb (
    .clk_i, .rst_ni, .stb_o(stb)
  );

  qdec_step #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_step (
    .clk_i, .rst_ni, .stb_i(stb), .mode_i(mode_e'(mode_i)), .ab_i(ab_s),
    .edge_o(cnt_edge), .pos_o(pos_l), .dir_o(dir_l), .err_o(err_l)
  );

  qdec_period #(.PER_W(PER_W)) u_per (
    .clk_i, .rst_ni, .stb_i(stb), .edge_i(cnt_edge), .per_o(per_l)
  );

  // coherent host snapshot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_o     <= '0;
      period_o  <= '1;
      dir_o     <= 1'b0;
      err_cnt_o <= '0;
    end else if (latch_i) begin
      pos_o     <= pos_l;
      period_o  <= per_l;
      dir_o     <= dir_l;
      err_cnt_o <= err_l;
    end
  end

  p_snap_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(pos_o) && $stable(period_o) && $stable(dir_o) && $stable(err_cnt_o));
  p_snap_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (pos_o == $past(pos_l)) && (period_o == $past(per_l)) && (err_cnt_o == $past(err_l)));
endmodule

// File: tb/tb_quad_sample_decoder.sv
module tb_quad_sample_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int CNT_W = 16;
  localparam int PER_W = 6;
  localparam int ERR_W = 3;
  localparam int NVEC  = 33;

  // {mode[1:0], a, b, exp_pos[15:0], exp_dir, exp_err[2:0]}
  localparam logic [23:0] VEC [NVEC] = '{
    {2'd3,1'b0,1'b1,16'h0001,1'b1,3'd0}, {2'd3,1'b1,1'b1,16'h0002,1'b1,3'd0},
    {2'd3,1'b1,1'b0,16'h0003,1'b1,3'd0}, {2'd3,1'b0,1'b0,16'h0004,1'b1,3'd0},
    {2'd3,1'b1,1'b0,16'h0003,1'b0,3'd0}, {2'd3,1'b1,1'b1,16'h0002,1'b0,3'd0},
    {2'd3,1'b0,1'b0,16'h0002,1'b0,3'd1}, {2'd3,1'b0,1'b1,16'h0003,1'b1,3'd1},
    {2'd1,1'b1,1'b1,16'h0004,1'b1,3'd1}, {2'd1,1'b0,1'b1,16'h0004,1'b1,3'd1},
    {2'd1,1'b0,1'b0,16'h0004,1'b1,3'd1}, {2'd1,1'b1,1'b0,16'h0003,1'b0,3'd1},
    {2'd1,1'b0,1'b0,16'h0003,1'b0,3'd1}, {2'd2,1'b0,1'b1,16'h0003,1'b0,3'd1},
    {2'd2,1'b1,1'b1,16'h0004,1'b1,3'd1}, {2'd2,1'b0,1'b1,16'h0003,1'b0,3'd1},
    {2'd2,1'b0,1'b0,16'h0003,1'b0,3'd1}, {2'd2,1'b1,1'b0,16'h0002,1'b0,3'd1},
    {2'd2,1'b0,1'b0,16'h0003,1'b1,3'd1}, {2'd2,1'b1,1'b1,16'h0003,1'b1,3'd2},
    {2'd0,1'b0,1'b1,16'h0003,1'b1,3'd2}, {2'd0,1'b1,1'b1,16'h0004,1'b1,3'd2},
    {2'd0,1'b0,1'b0,16'h0004,1'b1,3'd2}, {2'd0,1'b1,1'b0,16'h0005,1'b1,3'd2},
    {2'd0,1'b0,1'b0,16'h0005,1'b1,3'd2}, {2'd0,1'b1,1'b1,16'h0006,1'b1,3'd2},
    {2'd3,1'b0,1'b1,16'h0005,1'b0,3'd2}, {2'd3,1'b0,1'b0,16'h0004,1'b0,3'd2},
    {2'd3,1'b1,1'b0,16'h0003,1'b0,3'd2}, {2'd3,1'b1,1'b1,16'h0002,1'b0,3'd2},
    {2'd3,1'b0,1'b1,16'h0001,1'b0,3'd2}, {2'd3,1'b0,1'b0,16'h0000,1'b0,3'd2},
    {2'd3,1'b1,1'b0,16'hFFFF,1'b0,3'd2}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             a = 1'b0, b = 1'b0, latch = 1'b0;
  logic [1:0]       mode = 2'd3;
  logic [CNT_W-1:0] pos;
  logic [PER_W-1:0] period;
  logic             dir;
  logic [ERR_W-1:0] err_cnt;
  int               n_chk = 0, n_err = 0;
  bit               done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_sample_decoder #(.CLK_DIV(DIV), .CNT_W(CNT_W), .PER_W(PER_W), .ERR_W(ERR_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .mode_i(mode), .latch_i(latch),
    .pos_o(pos), .period_o(period), .dir_o(dir), .err_cnt_o(err_cnt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge hold*DIV clocks later, snapshot taken
  task automatic step(input logic [1:0] m, input logic av, input logic bv, input int hold);
    mode = m; a = av; b = bv;
    repeat (hold*DIV - 1) @(negedge clk);
    latch = 1'b1;
    @(negedge clk);
    latch = 1'b0;
  endtask

  function automatic string tag_of(input logic [1:0] m, input bit err_step);
    if (err_step) return "R6 both-change";
    case (m)
      2'd0:    return "R5 counter";
      2'd1:    return "R3 1x";
      2'd2:    return "R4 2x";
      default: return "R2 4x";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] last_err;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 pos", 32'(pos), 0);
    chk("R10 period", 32'(period), 32'h3F);
    chk("R10 dir", 32'(dir), 0);
    chk("R10 err", 32'(err_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);

    last_err = 3'd0;
    for (int i = 0; i < NVEC; i++) begin
      logic [23:0] v;
      v = VEC[i];
      step(v[23:22], v[21], v[20], 3);
      chk({tag_of(v[23:22], v[2:0] != last_err), " pos"}, 32'(pos), 32'(v[19:4]));
      chk({tag_of(v[23:22], v[2:0] != last_err), " dir"}, 32'(dir), 32'(v[3]));
      chk({tag_of(v[23:22], v[2:0] != last_err), " err"}, 32'(err_cnt), 32'(v[2:0]));
      last_err = v[2:0];
    end

    // R7 interval between counted edges, state now {1,0}, pos -1
    step(2'd3, 1'b1, 1'b1, 5);  // pos -2
    step(2'd3, 1'b0, 1'b1, 2);  // pos -3, previous gap 5
    chk("R7 period 5", 32'(period), 5);
    step(2'd3, 1'b0, 1'b0, 3);  // pos -4, previous gap 2
    chk("R7 period 2", 32'(period), 2);
    chk("R2 reverse pos", 32'(pos), 32'hFFFC);

    // R8 stopped
    repeat (70*DIV) @(negedge clk);
    latch = 1'b1; @(negedge clk); latch = 1'b0;
    chk("R8 stopped period", 32'(period), 32'h3F);

    // R6 error saturation
    for (int k = 0; k < 4; k++) begin
      step(2'd3, 1'b1, 1'b1, 3);
      step(2'd3, 1'b0, 1'b0, 3);
    end
    chk("R6 err saturates", 32'(err_cnt), 7);
    chk("R6 pos unchanged", 32'(pos), 32'hFFFC);

    // R1 synchroniser latency
    a = 1'b0; b = 1'b1; latch = 1'b1;
    @(negedge clk); latch = 1'b0;
    chk("R1 not yet sampled", 32'(pos), 32'hFFFC);
    repeat (3*DIV) @(negedge clk);
    latch = 1'b1; @(negedge clk); latch = 1'b0;
    chk("R1 sampled", 32'(pos), 32'hFFFD);

    // R9 snapshot hold and load
    a = 1'b1; b = 1'b1;
    repeat (3*DIV) @(negedge clk);
    chk("R9 hold without latch", 32'(pos), 32'hFFFD);
    latch = 1'b1; @(negedge clk); latch = 1'b0;
    chk("R9 loaded", 32'(pos), 32'hFFFE);
    chk("R9 loaded dir", 32'(dir), 1);

    // R10 reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R10 pos after reset", 32'(pos), 0);
    chk("R10 period after reset", 32'(period), 32'h3F);
    chk("R10 err after reset", 32'(err_cnt), 0);
    chk("R10 dir after reset", 32'(dir), 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule